// File: doc/BRIEF.md
# Word/Byte ALU with Condition Codes

This block is the integer execution stage of a 16-bit processor. Each cycle it can accept one operation, given as an operation code, a width bit, a source operand, a destination operand and the current four condition flags. One clock later it presents the result and the next flag values. It handles single-operand work (zeroing, inversion, increment and decrement, negation, carry propagation, rotates and shifts, byte swap, sign fill, test) and two-operand work (move, add, subtract, compare, bitwise set, clear, test and exclusive-or). It does not decode instructions and it does not access memory.

Each operation has its own rule for each flag. A flag may be computed, forced to 0 or 1, or passed through from the flag input. When the width bit is set, the operation works on the low byte only. The sign, zero, overflow and carry then refer to the byte, and the upper byte of the result is the upper byte of the destination. The caller writes `flags_out` back into its status register and feeds it in again on the next operation.

Top module: `alu_cc_unit`

## Requirements
- R1: The flag input and output are packed as {N,Z,V,C} in bits 3..0. The operation codes are: 0 zero, 1 invert, 2 increment, 3 decrement, 4 negate, 5 add-carry, 6 subtract-carry, 7 test, 8 rotate right, 9 rotate left, 10 arithmetic shift right, 11 arithmetic shift left, 12 byte swap, 13 sign fill, 14 move, 15 compare, 16 add, 17 subtract, 18 and-test, 19 clear bits, 20 set bits, 21 exclusive-or. Codes 22 to 31 return the destination unchanged and pass all four flags through.
- R2: The outputs are registered. A cycle with `in_valid` high produces `out_valid` high with that operation's result and flags one clock later. A cycle with `in_valid` low produces `out_valid` low and holds the result and flags. A synchronous reset (active low) clears all three outputs.
- R3: With `byte_mode`=1, every operation except byte swap and sign fill works on bits 7..0. N is bit 7 of the byte result, Z reports whether the byte is zero, and V and C use the byte's sign and carry positions (0x7F/0x80/0xFF). Result bits 15..8 equal destination bits 15..8.
- R4: Zero writes 0 and sets the flags to N=0, Z=1, V=0, C=0.
- R5: Invert writes the bitwise complement of the destination and computes N and Z from it. It forces V=0 and C=1.
- R6: Increment and decrement add or subtract 1 and compute N and Z. V is set only when the value crosses from the largest positive number to the most negative one (increment) or back (decrement). C passes through.
- R7: Negate writes the two's complement of the destination. V is set when the result is the most negative value. C is set when the result is nonzero.
- R8: Add-carry writes destination plus the incoming C, and subtract-carry writes destination minus the incoming C. All four flags are updated: V on signed overflow, C on carry out (add) or borrow (subtract).
- R9: Add writes source plus destination. Subtract writes destination minus source. Compare computes source minus destination for the flags only and returns the destination unchanged. C is carry out for add and borrow for subtract and compare, and V is signed overflow.
- R10: Move (result = source), and-test (flags from source AND destination, result = destination), clear bits (destination AND NOT source), set bits (OR) and exclusive-or all compute N and Z, clear V and pass C through. Test returns the destination and computes N and Z from it, with V=0 and C=0.
- R11: Rotate right and rotate left move the outgoing bit into C and the old C into the vacated end. Arithmetic shift right keeps the sign bit, and arithmetic shift left inserts 0, with the outgoing bit in C. For all four, V equals N XOR C after the operation.
- R12: Byte swap always works on the full word and exchanges its two bytes. N is bit 7 of the new word, Z reports whether the new low byte is zero, and V and C are cleared.
- R13: Sign fill always works on the full word. It writes all ones when the incoming N is 1 and all zeros otherwise. Z is set to NOT N, V is cleared, and N and C pass through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 5 | Operation code (R1) |
| byte_mode | input | 1 | 0 = word, 1 = low byte |
| src_opnd | input | 16 | Source operand |
| dst_opnd | input | 16 | Destination operand |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 16 | Operation result |
| flags_out | output | 4 | Next flags {N,Z,V,C} |

## Verification
Every operation code, including two unused ones, is run in both widths. The destination is swept across zero, 0x007F, 0x0080, 0x00FF, 0x7FFF, 0x8000, 0xFFFF and a mixed pattern, against several source values and four flag inputs. These sweeps separate the byte carry and sign positions from the word positions, and they show whether each flag is computed, forced or passed through. A block of pseudo-random stimulus then exercises bit patterns in the interior. Idle cycles between bursts confirm that the outputs hold.

// File: rtl/alu_cc_pkg.sv
// Shared operation codes and flag layout for the word/byte ALU.
// Assumes flags travel packed as {N,Z,V,C}, MSB first.
package alu_cc_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ZERO       = 5'd0,
        OP_INVERT     = 5'd1,
        OP_INC        = 5'd2,
        OP_DEC        = 5'd3,
        OP_NEGATE     = 5'd4,
        OP_ADD_C      = 5'd5,
        OP_SUB_C      = 5'd6,
        OP_TEST       = 5'd7,
        OP_ROT_R      = 5'd8,
        OP_ROT_L      = 5'd9,
        OP_SHR_A      = 5'd10,
        OP_SHL_A      = 5'd11,
        OP_SWAP       = 5'd12,
        OP_SEXT       = 5'd13,
        OP_MOVE       = 5'd14,
        OP_COMPARE    = 5'd15,
        OP_ADD        = 5'd16,
        OP_SUB        = 5'd17,
        OP_AND_TEST   = 5'd18,
        OP_CLEAR_BITS = 5'd19,
        OP_SET_BITS   = 5'd20,
        OP_XOR        = 5'd21
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

    // True for operations that go through the shared adder.
    function automatic logic uses_adder(alu_op_e op);
        case (op)
            OP_INC, OP_DEC, OP_NEGATE, OP_ADD_C, OP_SUB_C,
            OP_COMPARE, OP_ADD, OP_SUB: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu_cc_arith.sv
// Adder-based operations on a W-bit lane: increment, decrement, negate,
// add/subtract with carry, add, subtract, compare.
// All of them go through one (W+1)-bit adder whose operands are steered per
// operation. Assumes W >= 2. Outputs are meaningless for other opcodes.
module alu_cc_arith
    import alu_cc_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,      // destination
    input  logic [W-1:0]   b,      // source
    input  cc_t            cc_in,
    output logic [W-1:0]   res,
    output cc_t            cc_out
);

    logic [W-1:0] x, y;
    logic         ci;
    logic [W:0]   sum;
    logic         co, ovf;

    // Steer adder operands so every operation becomes x + y + ci.
    always_comb begin
        x  = a;
        y  = '0;
        ci = 1'b0;
        case (op)
            OP_INC:     begin x = a;  y = '0;                 ci = 1'b1; end
            OP_DEC:     begin x = a;  y = '1;                 ci = 1'b0; end
            OP_NEGATE:  begin x = '0; y = ~a;                 ci = 1'b1; end
            OP_ADD_C:   begin x = a;  y = '0;                 ci = cc_in.c; end
            OP_SUB_C:   begin x = a;  y = {W{cc_in.c}};       ci = 1'b0; end
            OP_COMPARE: begin x = b;  y = ~a;                 ci = 1'b1; end
            OP_ADD:     begin x = a;  y = b;                  ci = 1'b0; end
            OP_SUB:     begin x = a;  y = ~b;                 ci = 1'b1; end
            default:    begin x = a;  y = '0;                 ci = 1'b0; end
        endcase
    end

    assign sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    assign co  = sum[W];
    assign ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

    // Pick the carry rule for each operation; N, Z, V come from the adder.
    always_comb begin
        cc_out.n = sum[W-1];
        cc_out.z = (sum[W-1:0] == '0);
        cc_out.v = ovf;
        case (op)
            OP_ADD, OP_ADD_C:              cc_out.c = co;
            OP_SUB, OP_COMPARE, OP_NEGATE: cc_out.c = ~co;
            OP_SUB_C:                      cc_out.c = cc_in.c & ~co;
            default:                       cc_out.c = cc_in.c;
        endcase
    end

    // Compare only reports flags; the destination goes back unchanged.
    assign res = (op == OP_COMPARE) ? a : sum[W-1:0];

endmodule

// File: rtl/alu_cc_bitops.sv
// Non-adder operations on a W-bit lane: zero, invert, test, move, bitwise
// set/clear/test/xor, rotates through carry and arithmetic shifts.
// Unknown opcodes return the destination and pass every flag through.
// Assumes W >= 2.
module alu_cc_bitops
    import alu_cc_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,      // destination
    input  logic [W-1:0]   b,      // source
    input  cc_t            cc_in,
    output logic [W-1:0]   res,
    output cc_t            cc_out
);

    logic [W-1:0] r;
    logic         use_and;   // flags come from a & b rather than the result
    logic         upd_nz;
    logic         v_n, c_n;

    // Compute the result and the V/C policy of each operation.
    always_comb begin
        r       = a;
        use_and = 1'b0;
        upd_nz  = 1'b1;
        v_n     = 1'b0;
        c_n     = cc_in.c;
        case (op)
            OP_ZERO:       begin r = '0;                      c_n = 1'b0; end
            OP_INVERT:     begin r = ~a;                      c_n = 1'b1; end
            OP_TEST:       begin r = a;                       c_n = 1'b0; end
            OP_ROT_R:      begin r = {cc_in.c, a[W-1:1]};     c_n = a[0];
                                 v_n = cc_in.c ^ a[0];                     end
            OP_ROT_L:      begin r = {a[W-2:0], cc_in.c};     c_n = a[W-1];
                                 v_n = a[W-2] ^ a[W-1];                    end
            OP_SHR_A:      begin r = {a[W-1], a[W-1:1]};      c_n = a[0];
                                 v_n = a[W-1] ^ a[0];                      end
            OP_SHL_A:      begin r = {a[W-2:0], 1'b0};        c_n = a[W-1];
                                 v_n = a[W-2] ^ a[W-1];                    end
            OP_MOVE:       r = b;
            OP_AND_TEST:   begin r = a; use_and = 1'b1; end
            OP_CLEAR_BITS: r = a & ~b;
            OP_SET_BITS:   r = a | b;
            OP_XOR:        r = a ^ b;
            default:       begin r = a; upd_nz = 1'b0; v_n = cc_in.v; end
        endcase
    end

    logic [W-1:0] fsrc;
    assign fsrc = use_and ? (a & b) : r;

    // Merge computed N/Z with the V/C chosen above.
    always_comb begin
        cc_out.n = upd_nz ? fsrc[W-1]     : cc_in.n;
        cc_out.z = upd_nz ? (fsrc == '0)  : cc_in.z;
        cc_out.v = v_n;
        cc_out.c = c_n;
    end

    assign res = r;

endmodule

// File: rtl/alu_cc_lane.sv
// One W-bit execution lane: runs the adder unit and the bit unit side by
// side and forwards whichever one owns the current opcode.
module alu_cc_lane
    import alu_cc_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  cc_t            cc_in,
    output logic [W-1:0]   res,
    output cc_t            cc_out
);

    logic [W-1:0] res_add, res_bit;
    cc_t          cc_add, cc_bit;

    alu_cc_arith #(.W(W)) u_arith (
        .op(op), .a(a), .b(b), .cc_in(cc_in), .res(res_add), .cc_out(cc_add)
    );

    alu_cc_bitops #(.W(W)) u_bitops (
        .op(op), .a(a), .b(b), .cc_in(cc_in), .res(res_bit), .cc_out(cc_bit)
    );

    // Select the unit that implements this opcode.
    always_comb begin
        if (uses_adder(op)) begin
            res    = res_add;
            cc_out = cc_add;
        end else begin
            res    = res_bit;
            cc_out = cc_bit;
        end
    end

endmodule

// File: rtl/alu_cc_unit.sv
// Word/byte ALU top. A full-width lane and a half-width lane evaluate in
// parallel. The width bit picks one, and the byte result keeps the
// destination's upper half. Byte swap and sign fill are word-only and live
// here. Result and flags are registered once.
// Assumes DATA_W is even and at least 4.
module alu_cc_unit
    import alu_cc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] src_opnd,
    input  logic [DATA_W-1:0] dst_opnd,
    input  logic [3:0]        flags_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        flags_out
);

    localparam int BYTE_W = DATA_W / 2;
    localparam int N_LANE = 2;

    alu_op_e op;
    cc_t     cc_in;
    assign op    = alu_op_e'(op_sel);
    assign cc_in = cc_t'(flags_in);

    logic [DATA_W-1:0] res_word;
    logic [BYTE_W-1:0] res_byte;
    cc_t               cc_word, cc_byte;

    // Lane 0 is full width, lane 1 is the low half.
    for (genvar g = 0; g < N_LANE; g++) begin : gen_lane
        if (g == 0) begin : g_word
            alu_cc_lane #(.W(DATA_W)) u_lane (
                .op(op), .a(dst_opnd), .b(src_opnd), .cc_in(cc_in),
                .res(res_word), .cc_out(cc_word)
            );
        end else begin : g_byte
            alu_cc_lane #(.W(BYTE_W)) u_lane (
                .op(op), .a(dst_opnd[BYTE_W-1:0]), .b(src_opnd[BYTE_W-1:0]),
                .cc_in(cc_in), .res(res_byte), .cc_out(cc_byte)
            );
        end
    end

    logic [DATA_W-1:0] swapped;
    assign swapped = {dst_opnd[BYTE_W-1:0], dst_opnd[DATA_W-1:BYTE_W]};

    logic [DATA_W-1:0] nxt_res;
    cc_t               nxt_cc;

    // Choose between word-only operations, the byte lane and the word lane.
    always_comb begin
        if (op == OP_SWAP) begin
            nxt_res = swapped;
            nxt_cc  = '{n: swapped[BYTE_W-1], z: (swapped[BYTE_W-1:0] == '0),
                        v: 1'b0, c: 1'b0};
        end else if (op == OP_SEXT) begin
            nxt_res = {DATA_W{cc_in.n}};
            nxt_cc  = '{n: cc_in.n, z: ~cc_in.n, v: 1'b0, c: cc_in.c};
        end else if (byte_mode) begin
            nxt_res = {dst_opnd[DATA_W-1:BYTE_W], res_byte};
            nxt_cc  = cc_byte;
        end else begin
            nxt_res = res_word;
            nxt_cc  = cc_word;
        end
    end

    // Output register: capture on valid, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags_out <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= nxt_res;
                flags_out <= nxt_cc;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> (!out_valid && $stable(result) && $stable(flags_out))); // R2
    AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && byte_mode && op != OP_SWAP && op != OP_SEXT) |=> (result[DATA_W-1:BYTE_W] == $past(dst_opnd[DATA_W-1:BYTE_W]))); // R3
    AST_ZERO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op == OP_ZERO) |=> (flags_out == 4'b0100 && result[BYTE_W-1:0] == '0)); // R4
    AST_INVERT_VC: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op == OP_INVERT) |=> (flags_out[1:0] == 2'b01)); // R5
    AST_INCDEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && (op == OP_INC || op == OP_DEC)) |=> (flags_out[0] == $past(flags_in[0]))); // R6
    AST_SHIFT_V: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && (op == OP_ROT_R || op == OP_ROT_L || op == OP_SHR_A || op == OP_SHL_A)) |=> (flags_out[1] == (flags_out[3] ^ flags_out[0]))); // R11
    AST_SWAP_VC: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op == OP_SWAP) |=> (flags_out[1:0] == 2'b00)); // R12
    AST_SEXT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op == OP_SEXT) |=> (flags_out[3] == $past(flags_in[3]) && flags_out[2] == !$past(flags_in[3]) && flags_out[0] == $past(flags_in[0]))); // R13

endmodule

// File: tb/tb_alu_cc_unit.sv
`timescale 1ns/1ps
module tb_alu_cc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op_sel = '0;
    logic        byte_mode = 1'b0;
    logic [15:0] src_opnd = '0;
    logic [15:0] dst_opnd = '0;
    logic [3:0]  flags_in = '0;
    logic        out_valid;
    logic [15:0] result;
    logic [3:0]  flags_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] q_res[$];
    logic [3:0]  q_flg[$];
    string       q_tag[$];
    logic [15:0] last_res;
    logic [3:0]  last_flg;

    always #4 clk = ~clk;   // 125 MHz

    alu_cc_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .byte_mode(byte_mode), .src_opnd(src_opnd), .dst_opnd(dst_opnd),
        .flags_in(flags_in), .out_valid(out_valid), .result(result),
        .flags_out(flags_out)
    );

    // Requirement tag for each opcode (R3 added for byte mode).
    function automatic string req_tag(int op, bit bm);
        string t;
        case (op)
            0: t = "R4";   1: t = "R5";   2, 3: t = "R6";   4: t = "R7";
            5, 6: t = "R8";   8, 9, 10, 11: t = "R11";   12: t = "R12";
            13: t = "R13";   15, 16, 17: t = "R9";
            7, 14, 18, 19, 20, 21: t = "R10";
            default: t = "R1";
        endcase
        if (bm && op != 12 && op != 13) t = {"R3/", t};
        return t;
    endfunction

    // Reference model from the requirements: returns {N,Z,V,C,result}.
    function automatic logic [19:0] ref_model(int op, bit bm, logic [15:0] s,
                                              logic [15:0] d, logic [3:0] f);
        int mask = bm ? 'hFF : 'hFFFF;
        int sgn  = bm ? 'h80 : 'h8000;
        int a = int'(d) & mask;
        int b = int'(s) & mask;
        int ci = int'(f[0]);
        int r = a;
        int t;
        bit n = f[3], z = f[2], v = f[1], c = f[0];
        bit nz = 1'b1;
        logic [15:0] full;
        case (op)
            0:  begin r = 0; v = 0; c = 0; end
            1:  begin r = ~a & mask; v = 0; c = 1; end
            2:  begin r = (a + 1) & mask; v = (a == sgn - 1); end
            3:  begin r = (a - 1) & mask; v = (a == sgn); end
            4:  begin r = (-a) & mask; v = (r == sgn); c = (r != 0); end
            5:  begin r = (a + ci) & mask; v = (a == sgn - 1) && ci; c = (a == mask) && ci; end
            6:  begin r = (a - ci) & mask; v = (a == sgn) && ci; c = (a == 0) && ci; end
            7:  begin r = a; v = 0; c = 0; end
            8:  begin r = (a >> 1) | (ci != 0 ? sgn : 0); c = a[0]; end
            9:  begin r = ((a << 1) & mask) | ci; c = (a & sgn) != 0; end
            10: begin r = (a >> 1) | (a & sgn); c = a[0]; end
            11: begin r = (a << 1) & mask; c = (a & sgn) != 0; end
            14: begin r = b; v = 0; end
            15: begin
                    t = (b - a) & mask; r = a;
                    n = (t & sgn) != 0; z = (t == 0); nz = 0;
                    c = (b < a);
                    v = ((b ^ a) & sgn) != 0 && ((t ^ b) & sgn) != 0;
                end
            16: begin
                    t = a + b; r = t & mask; c = (t > mask);
                    v = ((a ^ b) & sgn) == 0 && ((r ^ a) & sgn) != 0;
                end
            17: begin
                    r = (a - b) & mask; c = (a < b);
                    v = ((a ^ b) & sgn) != 0 && ((r ^ a) & sgn) != 0;
                end
            18: begin t = a & b; r = a; n = (t & sgn) != 0; z = (t == 0); nz = 0; v = 0; end
            19: begin r = a & ~b & mask; v = 0; end
            20: begin r = a | b; v = 0; end
            21: begin r = a ^ b; v = 0; end
            default: nz = 0;
        endcase
        if (op == 12) begin
            full = {d[7:0], d[15:8]};
            return {full[7], full[7:0] == 8'h00, 1'b0, 1'b0, full};
        end
        if (op == 13) begin
            full = f[3] ? 16'hFFFF : 16'h0000;
            return {f[3], ~f[3], 1'b0, f[0], full};
        end
        if (nz) begin
            n = (r & sgn) != 0;
            z = (r == 0);
        end
        if (op >= 8 && op <= 11) v = n ^ c;
        full = bm ? {d[15:8], r[7:0]} : r[15:0];
        return {n, z, v, c, full};
    endfunction

    // Driver: present one operation and queue the expected outcome.
    task automatic send(int op, bit bm, logic [15:0] s, logic [15:0] d, logic [3:0] f);
        logic [19:0] e;
        @(negedge clk);
        op_sel = op[4:0]; byte_mode = bm; src_opnd = s; dst_opnd = d; flags_in = f;
        in_valid = 1'b1;
        e = ref_model(op, bm, s, d, f);
        q_res.push_back(e[15:0]);
        q_flg.push_back(e[19:16]);
        q_tag.push_back(req_tag(op, bm));
        last_res = e[15:0];
        last_flg = e[19:16];
    endtask

    // Go idle, then check that the outputs drop valid and hold (R2).
    task automatic idle_check();
        @(negedge clk);
        in_valid = 1'b0;
        op_sel = 5'd0;
        dst_opnd = 16'hDEAD;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== last_res || flags_out !== last_flg) begin
            errors++;
            $display("FAIL R2 idle hold: valid=%b res=%h flags=%b expected valid=0 res=%h flags=%b",
                     out_valid, result, flags_out, last_res, last_flg);
        end
    endtask

    // Monitor: compare each registered result with the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (q_res.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected output: res=%h flags=%b expected none", result, flags_out);
            end else begin
                logic [15:0] er;
                logic [3:0]  ef;
                string       tg;
                er = q_res.pop_front();
                ef = q_flg.pop_front();
                tg = q_tag.pop_front();
                if (result !== er || flags_out !== ef) begin
                    errors++;
                    $display("FAIL %s: res=%h flags=%b expected res=%h flags=%b",
                             tg, result, flags_out, er, ef);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] dlist [8];
        logic [15:0] slist [4];
        logic [3:0]  flist [4];
        logic [31:0] lfsr;
        dlist = '{16'h0000, 16'h007F, 16'h0080, 16'h00FF, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hA5C3};
        slist = '{16'h0001, 16'h7F80, 16'h8001, 16'hFFFF};
        flist = '{4'b0000, 4'b0001, 4'b1000, 4'b1111};

        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;   // R2 reset state
        if (out_valid !== 1'b0 || result !== 16'h0000 || flags_out !== 4'b0000) begin
            errors++;
            $display("FAIL R2 reset: valid=%b res=%h flags=%b expected 0 0000 0000",
                     out_valid, result, flags_out);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;   // R2 still idle after release
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2 idle after reset: valid=%b expected 0", out_valid);
        end

        // Directed sweep: every code (plus unused 22 and 31, R1), both widths.
        for (int op = 0; op < 24; op++) begin
            int code = (op == 22) ? 22 : (op == 23) ? 31 : op;
            for (int bm = 0; bm < 2; bm++) begin
                for (int di = 0; di < 8; di++)
                    for (int si = 0; si < 4; si++)
                        for (int fi = 0; fi < 4; fi++)
                            send(code, bm[0], slist[si], dlist[di], flist[fi]);
            end
            if (op % 6 == 5) idle_check();
        end
        idle_check();

        // Pseudo-random patterns across all codes.
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 3000; i++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            send(int'(lfsr[4:0]), lfsr[5], lfsr[31:16], lfsr[21:6], lfsr[9:6]);
        end
        idle_check();

        checks++;   // everything queued was observed
        if (q_res.size() != 0) begin
            errors++;
            $display("FAIL R2 missing outputs: left=%0d expected 0", q_res.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule